// File: doc/BRIEF.md
# Prioritized Interrupt Level and Vector Unit

This block decides which interrupt priority level the processor should take next and supplies the vector when the processor acknowledges that level. It compares the pending sources against the processor's current level every cycle. The sources are a halt pin, an interval-timer request, eight maskable hardware request lines that share one hardware level, and a vector of software requests at levels 1 to 15. The processor reads the result on `irq_level`. It then acknowledges by presenting a level on the acknowledge port and receives a 10-bit vector in the same cycle.

The hardware lines catch rising edges and hold them as sticky pending bits. Software sees them through one 32-bit control word. The low byte lane writes the 8-bit enable mask. The top byte lane is a write-one-to-clear port for pending bits. A read returns the pending bits in the top byte and the mask in the low byte. Hardware vectors come from a per-line table parameter, and only the low 10 bits of each entry are used. The timer has one fixed vector parameter.

Top module: `irq_level_vector_unit`

## Requirements
- R1: When `halt_pin` is 1, `irq_level` is HALT_LVL (31) whatever the current level and the other sources.
- R2: When the halt pin is low and the timer request is pending, `irq_level` is CLK_LVL (22) if `cur_ipl` < 22. The timer outranks hardware and software requests.
- R3: With no halt and no eligible timer, `irq_level` is HW_LVL (20) when (pending AND mask) is nonzero and `cur_ipl` < 20.
- R4: Otherwise, a software request bit i (1..15) is eligible only when i > `cur_ipl`, and the highest eligible bit gives the level. Bit 0 never raises a level, and no software level is reported when `cur_ipl` >= 15.
- R5: When no source qualifies, `irq_level` is 0. This includes the state right after reset, when the mask, the pending bits and the timer request are all 0.
- R6: An acknowledge at level 22 returns TIMER_VEC (0x0C0) on `ack_vec` in that cycle and clears the timer request at the next edge.
- R7: An acknowledge at level 20 picks the highest-numbered line i whose pending and mask bits are both 1. It returns VEC_TABLE[i] & 0x3FF and clears pending bit i at the next edge.
- R8: An acknowledge at level 20 with no unmasked pending line returns 0. An acknowledge at any level other than 20 or 22 returns 0 and changes no state. `ack_vec` is 0 whenever `ack_en` is 0.
- R9: A control write with `ctl_be[0]` = 1 loads the mask from `ctl_wdata[7:0]`; writes to lanes 1 and 2 change nothing. `ctl_rdata` = {pending[7:0], 16'h0000, mask[7:0]}.
- R10: A control write with `ctl_be[3]` = 1 clears every pending bit whose position is 1 in `ctl_wdata[31:24]`.
- R11: A hardware line becomes pending on a 0-to-1 transition of `hw_req[i]`, not while it is held high. A rising edge in the same cycle as a clear (from R7 or R10) leaves the bit set.
- R12: A `tmr_tick` pulse makes the timer request pending until it is acknowledged. A tick in the same cycle as a level-22 acknowledge leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_ipl | input | 5 | Current processor priority level |
| halt_pin | input | 1 | Halt request, level sensitive |
| tmr_tick | input | 1 | Interval-timer request pulse |
| hw_req | input | 8 | Hardware request lines, edge captured |
| sw_req | input | 16 | Software request bits, bit i is level i |
| ctl_we | input | 1 | Control word write strobe |
| ctl_be | input | 4 | Byte-lane enables of the control write |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Pending bits in 31:24, mask in 7:0 |
| ack_en | input | 1 | Acknowledge strobe |
| ack_ipl | input | 5 | Level being acknowledged |
| ack_vec | output | 10 | Vector for the acknowledged level |
| irq_level | output | 5 | Highest qualifying level, 0 when none |

## Verification
The hardest situation to reach is a collision at a single edge. A new rising edge on a hardware line can land in the same cycle as a lane-3 clear or an acknowledge that targets that same line. A timer tick can also coincide with a level-22 acknowledge. The stimulus gets there by holding `hw_req` low for one cycle so that the next cycle is a true rising edge, and by issuing the clear or acknowledge in exactly that cycle. A second pass holds the line high across a clear to show that a level alone does not set the bit again. A behavioural model in the bench steps alongside the design and checks level, vector and readback on every cycle.

// File: rtl/irq_lv_pkg.sv
// Package: shared constants and types for the interrupt level/vector unit.
// Assumes levels are 5-bit quantities.
package irq_lv_pkg;
    localparam int LVL_W = 5;
    typedef logic [LVL_W-1:0] lvl_t;

    // Source that produced the reported level.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_SW   = 3'd1,
        SRC_HW   = 3'd2,
        SRC_TMR  = 3'd3,
        SRC_HALT = 3'd4
    } irq_src_e;
endpackage

// File: rtl/irq_hw_lines.sv
// Module: hardware request lines. It captures rising edges into sticky
// pending bits, holds the enable mask, applies write-one-to-clear and
// acknowledge clears, and picks the highest unmasked line with its vector.
// Assumes NLINES <= 8 and VEC_W <= 32.
module irq_hw_lines #(
    parameter int NLINES = 8,
    parameter int VEC_W  = 10,
    parameter logic [NLINES-1:0][31:0] VEC_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] hw_in,
    input  logic              mask_we,
    input  logic [NLINES-1:0] mask_wdata,
    input  logic              clr_we,
    input  logic [NLINES-1:0] clr_wdata,
    input  logic              take,
    output logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] mask,
    output logic              any_unmasked,
    output logic [VEC_W-1:0]  take_vec
);
    localparam int SEL_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [NLINES-1:0] hw_q;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] unm;
    logic [NLINES-1:0] ack_clr;
    logic [NLINES-1:0] sw_clr;
    logic [SEL_W-1:0]  sel;
    logic              found;

    // Edge detect: a pending bit is set only on a 0-to-1 input transition.
    assign rise = hw_in & ~hw_q;
    assign unm  = pend & mask;
    assign any_unmasked = |unm;
    assign sw_clr = clr_we ? clr_wdata : '0;

    // Select the highest-numbered unmasked pending line.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NLINES; i++) begin
            if (unm[i]) begin
                sel   = SEL_W'(i);
                found = 1'b1;
            end
        end
    end

    // One-hot clear for the line that an acknowledge takes.
    always_comb begin
        ack_clr = '0;
        if (take && found) ack_clr[sel] = 1'b1;
    end

    // Vector lookup: low VEC_W bits of the table entry, 0 when nothing qualifies.
    always_comb begin
        take_vec = '0;
        if (found) take_vec = VEC_TABLE[sel][VEC_W-1:0];
    end

    // Registers: input history, sticky pending (set beats clear), mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q <= '0;
            pend <= '0;
            mask <= '0;
        end else begin
            hw_q <= hw_in;
            pend <= (pend & ~sw_clr & ~ack_clr) | rise;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_wdata)));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));

    assert_ack_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && any_unmasked && rise == '0 && !clr_we)
        |=> ($countones(pend) == $countones($past(pend)) - 1));

    assert_empty_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_unmasked |-> (take_vec == '0));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && rise == '0) |=> ((pend & $past(clr_wdata)) == '0));

    assert_rise_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_level_arb.sv
// Module: combinational level arbiter. Halt beats the timer, the timer
// beats hardware, and hardware beats software. Each source except halt is
// gated by the current processor level.
// Assumes HALT_LVL > CLK_LVL > HW_LVL > SW_TOP.
module irq_level_arb
    import irq_lv_pkg::*;
#(
    parameter int   SW_TOP   = 15,
    parameter lvl_t HALT_LVL = 5'd31,
    parameter lvl_t CLK_LVL  = 5'd22,
    parameter lvl_t HW_LVL   = 5'd20
) (
    input  lvl_t          cur_lvl,
    input  logic          halt,
    input  logic          tmr_pend,
    input  logic          hw_any,
    input  logic [SW_TOP:0] sw_req,
    output lvl_t          level,
    output irq_src_e      src
);
    lvl_t sw_lvl;
    logic sw_hit;

    // Software scan: the highest set bit above the current level.
    always_comb begin
        sw_lvl = '0;
        sw_hit = 1'b0;
        for (int i = 0; i <= SW_TOP; i++) begin
            if (sw_req[i] && (LVL_W'(i) > cur_lvl)) begin
                sw_lvl = LVL_W'(i);
                sw_hit = 1'b1;
            end
        end
    end

    // Fixed priority chain across the sources.
    always_comb begin
        level = '0;
        src   = SRC_NONE;
        if (halt) begin
            level = HALT_LVL;
            src   = SRC_HALT;
        end else if (tmr_pend && (cur_lvl < CLK_LVL)) begin
            level = CLK_LVL;
            src   = SRC_TMR;
        end else if (hw_any && (cur_lvl < HW_LVL)) begin
            level = HW_LVL;
            src   = SRC_HW;
        end else if (sw_hit) begin
            level = sw_lvl;
            src   = SRC_SW;
        end
    end
endmodule

// File: rtl/irq_level_vector_unit.sv
// Module: top of the interrupt level/vector unit. It holds the timer
// request, decodes the control word lanes and the acknowledge port, and
// joins the hardware line block with the level arbiter.
// Assumes one acknowledge per cycle at most and NLINES <= 8.
module irq_level_vector_unit
    import irq_lv_pkg::*;
#(
    parameter int   NLINES    = 8,
    parameter int   VEC_W     = 10,
    parameter int   SW_TOP    = 15,
    parameter lvl_t HALT_LVL  = 5'd31,
    parameter lvl_t CLK_LVL   = 5'd22,
    parameter lvl_t HW_LVL    = 5'd20,
    parameter logic [VEC_W-1:0] TIMER_VEC = 10'h0C0,
    parameter logic [NLINES-1:0][31:0] VEC_TABLE = {
        32'hC3C3_FD70, 32'hC3C3_FD60, 32'hC3C3_FD50, 32'hC3C3_FD40,
        32'hC3C3_FD30, 32'hC3C3_FD20, 32'hC3C3_FD10, 32'hC3C3_FD00}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  cur_ipl,
    input  logic              halt_pin,
    input  logic              tmr_tick,
    input  logic [NLINES-1:0] hw_req,
    input  logic [SW_TOP:0]   sw_req,
    input  logic              ctl_we,
    input  logic [3:0]        ctl_be,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              ack_en,
    input  logic [LVL_W-1:0]  ack_ipl,
    output logic [VEC_W-1:0]  ack_vec,
    output logic [LVL_W-1:0]  irq_level
);
    logic              tmr_pend;
    logic              tmr_take;
    logic              hw_take;
    logic              hw_any;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] mask;
    logic [VEC_W-1:0]  hw_vec;
    irq_src_e          src;

    assign tmr_take = ack_en && (ack_ipl == CLK_LVL);
    assign hw_take  = ack_en && (ack_ipl == HW_LVL);

    // Timer request: a tick sets it, a level-22 acknowledge clears it, and a tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_pend <= 1'b0;
        else        tmr_pend <= tmr_tick | (tmr_pend & ~tmr_take);
    end

    irq_hw_lines #(
        .NLINES   (NLINES),
        .VEC_W    (VEC_W),
        .VEC_TABLE(VEC_TABLE)
    ) hw_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_in       (hw_req),
        .mask_we     (ctl_we && ctl_be[0]),
        .mask_wdata  (ctl_wdata[NLINES-1:0]),
        .clr_we      (ctl_we && ctl_be[3]),
        .clr_wdata   (ctl_wdata[24 +: NLINES]),
        .take        (hw_take),
        .pend        (pend),
        .mask        (mask),
        .any_unmasked(hw_any),
        .take_vec    (hw_vec)
    );

    irq_level_arb #(
        .SW_TOP  (SW_TOP),
        .HALT_LVL(HALT_LVL),
        .CLK_LVL (CLK_LVL),
        .HW_LVL  (HW_LVL)
    ) arb_i (
        .cur_lvl (cur_ipl),
        .halt    (halt_pin),
        .tmr_pend(tmr_pend),
        .hw_any  (hw_any),
        .sw_req  (sw_req),
        .level   (irq_level),
        .src     (src)
    );

    // Acknowledge vector mux: timer, hardware table, or 0.
    always_comb begin
        ack_vec = '0;
        if (tmr_take)     ack_vec = TIMER_VEC;
        else if (hw_take) ack_vec = hw_vec;
    end

    // Readback: pending bits in the top lane, mask in the bottom lane.
    assign ctl_rdata = (32'(pend) << 24) | 32'(mask);

    assert_halt_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pin |-> (irq_level == HALT_LVL));

    assert_timer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_pin && tmr_pend && cur_ipl < CLK_LVL) |-> (irq_level == CLK_LVL));

    assert_hw_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_HW) |-> (hw_any && cur_ipl < HW_LVL && irq_level == HW_LVL));

    assert_sw_above_cur_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SW) |-> (irq_level > cur_ipl && irq_level <= LVL_W'(SW_TOP)));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_pin && !tmr_pend && !hw_any && sw_req[SW_TOP:1] == '0) |-> (irq_level == '0));

    assert_tmr_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_take && !tmr_tick) |=> !tmr_pend);

    assert_idle_ack_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |-> (ack_vec == '0));

    assert_tick_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick |=> tmr_pend);
endmodule

// File: tb/irq_level_vector_unit_tb_top.sv
// Bench: a behavioural reference model steps with the design, and the bench
// compares level, vector and readback on every cycle.
module irq_level_vector_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cur_ipl;
    logic        halt_pin, tmr_tick;
    logic [7:0]  hw_req;
    logic [15:0] sw_req;
    logic        ctl_we;
    logic [3:0]  ctl_be;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic        ack_en;
    logic [4:0]  ack_ipl;
    logic [9:0]  ack_vec;
    logic [4:0]  irq_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model state.
    int m_mask, m_pend, m_hwq, m_tmr;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cur_ipl(cur_ipl), .halt_pin(halt_pin),
        .tmr_tick(tmr_tick), .hw_req(hw_req), .sw_req(sw_req),
        .ctl_we(ctl_we), .ctl_be(ctl_be), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ack_en(ack_en), .ack_ipl(ack_ipl),
        .ack_vec(ack_vec), .irq_level(irq_level)
    );

    function automatic int exp_level();
        int unm = m_pend & m_mask;
        if (halt_pin) return 31;
        if (m_tmr != 0 && cur_ipl < 22) return 22;
        if (unm != 0 && cur_ipl < 20) return 20;
        for (int i = 15; i >= 1; i--)
            if (sw_req[i] && i > cur_ipl) return i;
        return 0;
    endfunction

    function automatic int exp_vec();
        int unm = m_pend & m_mask;
        if (!ack_en) return 0;
        if (ack_ipl == 22) return 'h0C0;
        if (ack_ipl == 20)
            for (int i = 7; i >= 0; i--)
                if ((unm >> i) & 1) return 'h100 + 16 * i;
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: inputs already driven; compare, cross the edge, update the model.
    task automatic step(string tag);
        int e_lvl, e_vec, e_rd, unm, rise, nxt;
        #1;
        e_lvl = exp_level();
        e_vec = exp_vec();
        e_rd  = ((m_pend & 'hFF) << 24) | (m_mask & 'hFF);
        check(tag, "irq_level", int'(irq_level), e_lvl);
        check(tag, "ack_vec",   int'(ack_vec),   e_vec);
        check(tag, "ctl_rdata", int'(ctl_rdata), e_rd);
        unm  = m_pend & m_mask;
        rise = hw_req & ~m_hwq & 'hFF;
        nxt  = m_pend;
        if (ctl_we && ctl_be[3]) nxt = nxt & ~int'(ctl_wdata[31:24]);
        if (ack_en && ack_ipl == 20)
            for (int i = 7; i >= 0; i--)
                if ((unm >> i) & 1) begin nxt = nxt & ~(1 << i); break; end
        nxt = nxt | rise;
        @(posedge clk);
        m_pend = nxt;
        m_hwq  = hw_req;
        if (ctl_we && ctl_be[0]) m_mask = ctl_wdata[7:0];
        if (ack_en && ack_ipl == 22) m_tmr = 0;
        if (tmr_tick) m_tmr = 1;
        @(negedge clk);
        tmr_tick = 0; ctl_we = 0; ctl_be = 0; ack_en = 0; ctl_wdata = 0;
    endtask

    task automatic wr(logic [3:0] be, logic [31:0] d);
        ctl_we = 1; ctl_be = be; ctl_wdata = d;
    endtask

    task automatic ack(logic [4:0] l);
        ack_en = 1; ack_ipl = l;
    endtask

    initial begin
        rst_n = 0; cur_ipl = 0; halt_pin = 0; tmr_tick = 0; hw_req = 0;
        sw_req = 0; ctl_we = 0; ctl_be = 0; ctl_wdata = 0; ack_en = 0; ack_ipl = 0;
        m_mask = 0; m_pend = 0; m_hwq = 0; m_tmr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R5: reset state.
        step("R5");
        // R1: halt wins at the highest current level.
        halt_pin = 1; cur_ipl = 31; sw_req = 16'hFFFE; step("R1");
        halt_pin = 0; cur_ipl = 0; sw_req = 0;
        // R12 / R2: timer set, then gated by the current level.
        tmr_tick = 1; step("R12");
        cur_ipl = 21; step("R2");
        cur_ipl = 22; step("R2");
        // R6: acknowledge the timer, then R12 tick racing an acknowledge.
        cur_ipl = 0; ack(22); step("R6");
        step("R6");
        ack(22); tmr_tick = 1; step("R12");
        step("R12");
        ack(22); step("R6");
        // R9: mask write, lanes 1/2 ignored.
        wr(4'b0001, 32'h0000_00FF); step("R9");
        wr(4'b0110, 32'h00AB_CD00); step("R9");
        // R11: rising edges on lines 3 and 6.
        hw_req = 8'h48; step("R11");
        cur_ipl = 19; step("R3");
        cur_ipl = 20; step("R3");
        // R7: acknowledges take line 6, then line 3; R8: then empty.
        cur_ipl = 0; ack(20); step("R7");
        ack(20); step("R7");
        ack(20); step("R8");
        // R11: held-high lines do not re-set.
        step("R11");
        hw_req = 8'h00; step("R11");
        // R11: a rising edge with a same-cycle clear keeps the bit.
        hw_req = 8'h01; wr(4'b1000, 32'h0100_0000); step("R11");
        step("R11");
        // R10: write-one-to-clear removes it.
        wr(4'b1000, 32'hFF00_0000); step("R10");
        step("R10");
        // R11: rising edge in the same cycle as an acknowledge of that line.
        hw_req = 8'h00; step("R11");
        hw_req = 8'h01; step("R11");
        hw_req = 8'h00; step("R11");
        hw_req = 8'h01; ack(20); step("R11");
        step("R11");
        wr(4'b1000, 32'h0100_0000); step("R10");
        // R3/R8: masked-off pending line.
        wr(4'b0001, 32'h0F); hw_req = 8'h40; step("R3");
        step("R3");
        ack(20); step("R8");
        ack(15); step("R8");
        // R4: software scan.
        hw_req = 0; wr(4'b1001, 32'hFF00_00FF); step("R10");
        sw_req = 16'h8013; cur_ipl = 0; step("R4");
        cur_ipl = 15; step("R4");
        cur_ipl = 3; step("R4");
        sw_req = 16'h0013; cur_ipl = 4; step("R4");
        sw_req = 16'h0001; cur_ipl = 0; step("R4");
        // R2/R3 priority: timer and hardware together.
        sw_req = 16'hFFFF; hw_req = 8'h04; tmr_tick = 1; step("R2");
        step("R2");
        cur_ipl = 22; step("R3");
        halt_pin = 1; step("R1");
        halt_pin = 0; cur_ipl = 0; ack(22); step("R6");
        ack(20); step("R7");
        step("R5");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule